// File: doc/BRIEF.md
# Sixteen-Pin Memory-Mapped GPIO Port

This block is a 16-pin general-purpose I/O port on a simple 32-bit register bus. Software writes an output latch whose bits drive the pins, and it reads back the pin levels after a two-stage synchronizer. Two 32-bit configuration words sit in the same register window as plain storage. Their meaning is left to surrounding logic.

A write-only set/clear register changes individual output bits in one bus write. Each 1 in its lower half forces the matching output high. Each 1 in its upper half forces the matching output low. Zeros leave the bit alone. Several agents can therefore change disjoint pins without a read-modify-write sequence and without racing each other.

The bus side has a byte offset, write data, a write strobe and a read strobe. Read data is returned one clock after the read strobe. Every register update takes effect at the clock edge that samples the write.

Top module: `gpio_port16`

## Requirements
- R1: A synchronous active-low reset clears the output latch (pin_out = 0x0000), both configuration words and the read data to zero.
- R2: A write to offset 0x0C loads bus_wdata[15:0] into the output latch at the sampling edge, and bit i drives pin_out[i] (1 = high). Bits [31:16] of the write are ignored, and a read of 0x0C returns the latch in [15:0] with zeros in [31:16].
- R3: A write to offset 0x18 sets pin_out[i] for each bus_wdata[i] = 1 (i = 0..15) and clears pin_out[i] for each bus_wdata[16+i] = 1. A pin whose two bits are both 0 keeps its value.
- R4: When one write to offset 0x18 has both bus_wdata[i] and bus_wdata[16+i] at 1, pin i ends up high (set wins).
- R5: Offset 0x18 is write-only, and a read of it returns 0x00000000.
- R6: Offset 0x08 is read-only. A read returns pin_in after two synchronizing flops in [15:0], with zeros in [31:16]. A change on pin_in first shows in a read captured at the third edge after it, and writes to 0x08 change nothing.
- R7: Offsets 0x00 and 0x04 hold two independent 32-bit configuration words with full write and readback.
- R8: Offsets outside {0x00, 0x04, 0x08, 0x0C, 0x18} are unmapped, and so is any offset whose bits [1:0] are not zero. Unmapped reads return zero, and unmapped writes change no register and no pin.
- R9: bus_rdata carries the value addressed by a read in the cycle after bus_re is high, and it is zero in the cycle after bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the port's register window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per high cycle |
| bus_re | input | 1 | Read strobe, data returned next cycle |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels to be sampled |
| pin_out | output | 16 | Output levels driven onto the pins |

## Verification
The bench drives a set/clear write that sets and clears the same pin. A design that gave the clear priority would leave that pin low. It sends an all-zero set/clear word, which a design that treated it as a plain store would use to wipe the latch. It also reads the write-only offset, where a leaky mux would return the latch.

The bench times the input path edge by edge: a one-flop synchronizer would show a new pin level one read too early. Misaligned offsets, unmapped offsets and writes to the input register are checked against both the pins and the configuration words. An over-eager decoder would corrupt one of them.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types of the GPIO port.
// Assumes a byte-addressed window with 32-bit, word-aligned registers.
package gpio_port_pkg;

    localparam int PORT_DATA_W = 32;
    localparam int PORT_PIN_W  = 16;
    localparam int PORT_ADDR_W = 8;

    // Byte offsets inside the window; software depends on these positions.
    localparam int OFF_CFG_LO  = 'h00;
    localparam int OFF_CFG_HI  = 'h04;
    localparam int OFF_PIN_IN  = 'h08;
    localparam int OFF_PIN_OUT = 'h0C;
    localparam int OFF_SET_CLR = 'h18;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CFG_LO,
        REG_CFG_HI,
        REG_PIN_IN,
        REG_PIN_OUT,
        REG_SET_CLR
    } reg_id_e;

endpackage

// File: rtl/gpio_port_decode.sv
// Address decoder: maps a byte offset onto one register of the window.
// Assumes registers are word aligned; a misaligned offset selects nothing.
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = PORT_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           reg_id
);

    // Compare the whole offset, low bits included, against each register.
    always_comb begin
        reg_id = REG_NONE;
        if (addr == ADDR_W'(OFF_CFG_LO))       reg_id = REG_CFG_LO;
        else if (addr == ADDR_W'(OFF_CFG_HI))  reg_id = REG_CFG_HI;
        else if (addr == ADDR_W'(OFF_PIN_IN))  reg_id = REG_PIN_IN;
        else if (addr == ADDR_W'(OFF_PIN_OUT)) reg_id = REG_PIN_OUT;
        else if (addr == ADDR_W'(OFF_SET_CLR)) reg_id = REG_SET_CLR;
    end

endmodule

// File: rtl/gpio_port_sync.sv
// Input synchronizer: a chain of STAGES flops per pin bit.
// Assumes pin_in is asynchronous to clk; output is STAGES edges late.
module gpio_port_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_outreg.sv
// Output latch with direct load and per-bit set/clear.
// Assumes the direct and set/clear strobes never arrive together, and that
// DATA_W holds a set half and a clear half of PIN_W bits each.
module gpio_port_outreg #(
    parameter int PIN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_direct,
    input  logic              wr_setclr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PIN_W-1:0]  out_q
);

    logic [PIN_W-1:0] set_bits;
    logic [PIN_W-1:0] clr_bits;
    logic [PIN_W-1:0] out_d;

    assign set_bits = wdata[PIN_W-1:0];
    assign clr_bits = wdata[2*PIN_W-1:PIN_W];

    for (genvar i = 0; i < PIN_W; i++) begin : g_bit
        // Next value of one pin: direct load, else set beats clear, else hold.
        always_comb begin
            out_d[i] = out_q[i];
            if (wr_direct)          out_d[i] = wdata[i];
            else if (wr_setclr) begin
                if (set_bits[i])      out_d[i] = 1'b1;
                else if (clr_bits[i]) out_d[i] = 1'b0;
            end
        end
    end

    // Latch the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_direct |=> out_q == $past(wdata[PIN_W-1:0])); // R2
    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setclr |=> (out_q & $past(set_bits)) == $past(set_bits)); // R3
    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setclr |=> (out_q & $past(clr_bits & ~set_bits)) == '0); // R3
    AST_UNTOUCHED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_setclr |=> (out_q & ~$past(set_bits | clr_bits)) ==
                      ($past(out_q) & ~$past(set_bits | clr_bits))); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_setclr && |(set_bits & clr_bits)) |=>
        (out_q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_direct && !wr_setclr) |=> $stable(out_q)); // R8

endmodule

// File: rtl/gpio_port16.sv
// Sixteen-pin GPIO port on a 32-bit register bus.
// Holds two configuration words, an output latch with set/clear access and
// a synchronized input view; read data is registered (one-cycle latency).
// Assumes at most one of bus_we/bus_re per cycle carries a useful access.
module gpio_port16
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W      = PORT_ADDR_W,
    parameter int DATA_W      = PORT_DATA_W,
    parameter int PIN_W       = PORT_PIN_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out
);

    localparam int CFG_N = 2;

    reg_id_e           reg_id;
    logic [PIN_W-1:0]  in_sync;
    logic [DATA_W-1:0] cfg_q [CFG_N];
    logic [CFG_N-1:0]  cfg_wr;
    logic [DATA_W-1:0] rd_mux;

    gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .reg_id (reg_id)
    );

    gpio_port_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpio_port_outreg #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_direct (bus_we && reg_id == REG_PIN_OUT),
        .wr_setclr (bus_we && reg_id == REG_SET_CLR),
        .wdata     (bus_wdata),
        .out_q     (pin_out)
    );

    for (genvar c = 0; c < CFG_N; c++) begin : g_cfg
        assign cfg_wr[c] = bus_we &&
                           reg_id == ((c == 0) ? REG_CFG_LO : REG_CFG_HI);
        // Store one configuration word.
        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q[c] <= '0;
            else if (cfg_wr[c]) cfg_q[c] <= bus_wdata;
        end
    end

    // Select the readable value; write-only and unmapped offsets give zero.
    always_comb begin
        unique case (reg_id)
            REG_CFG_LO:  rd_mux = cfg_q[0];
            REG_CFG_HI:  rd_mux = cfg_q[1];
            REG_PIN_IN:  rd_mux = {{(DATA_W-PIN_W){1'b0}}, in_sync};
            REG_PIN_OUT: rd_mux = {{(DATA_W-PIN_W){1'b0}}, pin_out};
            default:     rd_mux = '0;
        endcase
    end

    // Register read data; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> bus_rdata == '0); // R9
    AST_RD_SETCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && reg_id == REG_SET_CLR) |=> bus_rdata == '0); // R5
    AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && reg_id == REG_NONE) |=> bus_rdata == '0); // R8
    AST_RD_IN_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && reg_id == REG_PIN_IN) |=> bus_rdata[DATA_W-1:PIN_W] == '0); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(cfg_q[0]) && $stable(cfg_q[1]))); // R7

endmodule

// File: tb/gpio_port16_test.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module gpio_port16_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [15:0] exp_pin;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h0C, 32'hFFFF1234, 32'h0,        16'h1234, 4'd2}, // R2 load, upper ignored
        '{1'b0, 8'h0C, 32'h0,        32'h00001234, 16'h1234, 4'd2}, // R2 readback
        '{1'b1, 8'h18, 32'h000000C1, 32'h0,        16'h12F5, 4'd3}, // R3 set bits
        '{1'b1, 8'h18, 32'h12000000, 32'h0,        16'h00F5, 4'd3}, // R3 clear bits
        '{1'b1, 8'h18, 32'h01000100, 32'h0,        16'h01F5, 4'd4}, // R4 set wins
        '{1'b1, 8'h18, 32'h00000000, 32'h0,        16'h01F5, 4'd3}, // R3 zero word
        '{1'b0, 8'h18, 32'h0,        32'h0,        16'h01F5, 4'd5}, // R5 write-only
        '{1'b0, 8'h08, 32'h0,        32'h0000A5C3, 16'h01F5, 4'd6}, // R6 input view
        '{1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        16'h01F5, 4'd6}, // R6 write ignored
        '{1'b0, 8'h08, 32'h0,        32'h0000A5C3, 16'h01F5, 4'd6}, // R6 still inputs
        '{1'b1, 8'h00, 32'hDEADBEEF, 32'h0,        16'h01F5, 4'd7}, // R7
        '{1'b0, 8'h00, 32'h0,        32'hDEADBEEF, 16'h01F5, 4'd7}, // R7
        '{1'b1, 8'h04, 32'h01234567, 32'h0,        16'h01F5, 4'd7}, // R7
        '{1'b0, 8'h04, 32'h0,        32'h01234567, 16'h01F5, 4'd7}, // R7
        '{1'b0, 8'h00, 32'h0,        32'hDEADBEEF, 16'h01F5, 4'd7}, // R7 independent
        '{1'b1, 8'h10, 32'hFFFFFFFF, 32'h0,        16'h01F5, 4'd8}, // R8 unmapped write
        '{1'b0, 8'h10, 32'h0,        32'h0,        16'h01F5, 4'd8}, // R8 unmapped read
        '{1'b1, 8'h1C, 32'h0000FFFF, 32'h0,        16'h01F5, 4'd8}, // R8
        '{1'b0, 8'h14, 32'h0,        32'h0,        16'h01F5, 4'd8}, // R8
        '{1'b1, 8'h0E, 32'h0000FFFF, 32'h0,        16'h01F5, 4'd8}, // R8 misaligned write
        '{1'b1, 8'h19, 32'h0000FFFF, 32'h0,        16'h01F5, 4'd8}, // R8 misaligned set/clear
        '{1'b0, 8'h0D, 32'h0,        32'h0,        16'h01F5, 4'd8}, // R8 misaligned read
        '{1'b0, 8'h00, 32'h0,        32'hDEADBEEF, 16'h01F5, 4'd8}, // R8 cfg untouched
        '{1'b0, 8'h04, 32'h0,        32'h01234567, 16'h01F5, 4'd8}  // R8 cfg untouched
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = 16'hA5C3;
    logic [15:0] pin_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port16 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    task automatic check(input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample at the next falling edge.
    task automatic access(input logic wr, input logic [7:0] addr,
                          input logic [31:0] data,
                          output logic [31:0] rd, output logic [15:0] pin);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = data;
        bus_we    = wr;
        bus_re    = ~wr;
        @(negedge clk);
        rd  = bus_rdata;
        pin = pin_out;
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] pin;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("pins after reset", 1, {16'h0, pin_out}, 32'h0);
        check("rdata after reset", 1, bus_rdata, 32'h0);
        access(1'b0, 8'h00, 32'h0, rd, pin);
        check("cfg lo after reset", 1, rd, 32'h0);
        access(1'b0, 8'h04, 32'h0, rd, pin);
        check("cfg hi after reset", 1, rd, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            access(VEC[v].is_wr, VEC[v].addr, VEC[v].data, rd, pin);
            check($sformatf("vector %0d pins", v), int'(VEC[v].req),
                  {16'h0, pin}, {16'h0, VEC[v].exp_pin});
            if (!VEC[v].is_wr)
                check($sformatf("vector %0d rdata", v), int'(VEC[v].req),
                      rd, VEC[v].exp_rd);
        end

        // R9: data appears one cycle after the strobe, zero once it drops.
        @(negedge clk);
        bus_addr = 8'h00;
        bus_re   = 1'b1;
        check("rdata before read edge", 9, bus_rdata, 32'h0);
        @(negedge clk);
        bus_re = 1'b0;
        check("rdata one cycle later", 9, bus_rdata, 32'hDEADBEEF);
        @(negedge clk);
        check("rdata after strobe drops", 9, bus_rdata, 32'h0);

        // R6: two-flop input delay, read held across three edges.
        @(negedge clk);
        pin_in   = 16'h5A3C;
        bus_addr = 8'h08;
        bus_re   = 1'b1;
        @(negedge clk);
        check("input read edge 1", 6, bus_rdata, 32'h0000A5C3);
        @(negedge clk);
        check("input read edge 2", 6, bus_rdata, 32'h0000A5C3);
        @(negedge clk);
        check("input read edge 3", 6, bus_rdata, 32'h00005A3C);
        bus_re = 1'b0;

        // R2: a direct load overwrites all set/clear results.
        access(1'b1, 8'h0C, 32'h0000800F, rd, pin);
        check("direct load after set/clear", 2, {16'h0, pin}, 32'h0000800F);

        // R1: reset again in mid-operation.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("pins after second reset", 1, {16'h0, pin_out}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 8'h00, 32'h0, rd, pin);
        check("cfg lo after second reset", 1, rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule